// File: doc/BRIEF.md
# Host-to-CPU Interrupt Status Controller

This block keeps one 32-bit interrupt status word that two parties share: an external host and an embedded CPU. The host raises general-purpose message interrupts by writing ones into the low sixteen bits. The CPU acknowledges any pending bit by writing ones to a separate acknowledge location. A CPU-owned enable word masks which pending bits drive the single, registered CPU interrupt line.

Three single-cycle pulses from a DMA engine also raise status bits: write finished, read finished, and read FIFO ready. The block also watches the host port while the device is asleep. Any host access that targets something other than this interrupt register raises a sleep-violation flag in bit 31. Accesses to the interrupt register itself are exempt. The same status word, flag included, is mirrored back to the host, so the host can see the violation and wait for the CPU to deal with it.

Top module: `irq_status_ctrl`

## Requirements
- R1: Status bits 27:16 always read as zero, and neither a host write nor a CPU acknowledge can set or disturb them.
- R2: A host write with `host_irq_sel`=1 sets each status bit 15:0 whose data bit is 1. Bits written as 0 keep their value. Data bits 31:16 of a host write have no effect.
- R3: A CPU write to register 1 (acknowledge) clears each status bit whose data bit is 1 and leaves every other bit unchanged.
- R4: When a set source and an acknowledge hit the same bit in the same cycle, the bit ends up set.
- R5: A one-cycle pulse on `dma_wr_done`, `dma_rd_done` or `dma_rd_ready` sets status bit 30, 29 or 28 respectively. The bit stays set until it is acknowledged.
- R6: A host access (read or write) with `host_irq_sel`=0 while `sleep_mode`=1 sets status bit 31.
- R7: A host access with `host_irq_sel`=1 during sleep never sets bit 31, although a write still sets message bits. A host access outside sleep never sets bit 31.
- R8: `host_status` always equals the status word that a CPU read of register 0 returns. This includes bit 31.
- R9: CPU register 2 is the 32-bit enable word, which is writable, readable and resets to zero. A CPU read of register 0 returns status. Reads of registers 1 and 3 return zero. A CPU write to register 0 changes nothing. `cpu_rdata` is zero unless a CPU read is presented.
- R10: `cpu_irq` is a register loaded each cycle with the OR of (status AND enable). It therefore follows a status or enable change one cycle after that change becomes visible.
- R11: After reset, the status word, the enable word and `cpu_irq` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_valid | input | 1 | Host access presented this cycle |
| host_write | input | 1 | Host access is a write (1) or a read (0) |
| host_irq_sel | input | 1 | Host access targets this interrupt register (1) or other device space (0) |
| host_wdata | input | 32 | Host write data, ones set message bits |
| host_status | output | 32 | Status word as seen by the host |
| cpu_valid | input | 1 | CPU access presented this cycle |
| cpu_write | input | 1 | CPU access is a write |
| cpu_addr | input | 2 | CPU register: 0 status, 1 acknowledge, 2 enable, 3 spare |
| cpu_wdata | input | 32 | CPU write data |
| cpu_rdata | output | 32 | CPU read data, same cycle as the read |
| sleep_mode | input | 1 | Device is in sleep mode |
| dma_wr_done | input | 1 | DMA write-complete pulse |
| dma_rd_done | input | 1 | DMA read-complete pulse |
| dma_rd_ready | input | 1 | DMA read-FIFO-ready pulse |
| cpu_irq | output | 1 | Registered CPU interrupt request |

## Verification
The hardest cases to reach from the ports are the ones where two things happen in the same cycle. One is a set source and an acknowledge landing on one bit together. The other is a host access during sleep whose address selection decides whether bit 31 rises. The stimulus drives a host message write together with an acknowledge of that same bit, and a DMA pulse together with its own acknowledge. In sleep, it sends host reads and writes to the interrupt register first and to other device space second. It clears bit 31 between these cases so that each outcome can be seen on its own. It also enables bit 31 alone, to show that a violation can reach the interrupt line.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
  localparam int unsigned WORD_W      = 32;
  localparam int unsigned BIT_SLEEP   = 31;
  localparam int unsigned BIT_DMA_WR  = 30;
  localparam int unsigned BIT_DMA_RD  = 29;
  localparam int unsigned BIT_DMA_RDY = 28;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {
    CPU_REG_STATUS = 2'd0,
    CPU_REG_ACK    = 2'd1,
    CPU_REG_ENABLE = 2'd2,
    CPU_REG_SPARE  = 2'd3
  } cpu_reg_e;

  // Bits owned by the host message field.
  function automatic word_t msg_mask(input int unsigned msg_w);
    word_t m;
    m = '0;
    for (int unsigned i = 0; i < msg_w; i++) m[i] = 1'b1;
    return m;
  endfunction

  // Bits raised by hardware events.
  function automatic word_t hw_mask();
    word_t m;
    m = '0;
    m[BIT_SLEEP]   = 1'b1;
    m[BIT_DMA_WR]  = 1'b1;
    m[BIT_DMA_RD]  = 1'b1;
    m[BIT_DMA_RDY] = 1'b1;
    return m;
  endfunction

  function automatic word_t impl_mask(input int unsigned msg_w);
    return msg_mask(msg_w) | hw_mask();
  endfunction

  function automatic word_t event_vec(input logic sleep_hit, input logic wr_done,
                                      input logic rd_done, input logic rd_ready);
    word_t v;
    v = '0;
    v[BIT_SLEEP]   = sleep_hit;
    v[BIT_DMA_WR]  = wr_done;
    v[BIT_DMA_RD]  = rd_done;
    v[BIT_DMA_RDY] = rd_ready;
    return v;
  endfunction

  // Set wins over clear; unimplemented bits forced to zero.
  function automatic word_t next_status(input word_t cur, input word_t set_v,
                                        input word_t clr_v, input int unsigned msg_w);
    return ((cur & ~clr_v) | set_v) & impl_mask(msg_w);
  endfunction
endpackage

// File: rtl/irq_sleep_guard.sv
module irq_sleep_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic host_valid,
  input  logic host_irq_sel,
  input  logic sleep_mode,
  output logic sleep_hit
);
  logic foreign_access;

  assign foreign_access = host_valid && !host_irq_sel;
  assign sleep_hit      = foreign_access && sleep_mode;

  // R7: accesses to the interrupt register itself never flag
  a_r7_exempt: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && host_irq_sel) |-> !sleep_hit);
  // R7: no flag outside sleep
  a_r7_awake: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_mode |-> !sleep_hit);
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
  import irq_status_pkg::*;
#(
  parameter int unsigned MSG_W = 16
) (
  input  logic  clk,
  input  logic  rst_n,
  input  word_t set_vec,
  input  word_t clr_vec,
  output word_t status
);
  localparam word_t IMPL = impl_mask(MSG_W);

  word_t status_q;

  always_ff @(posedge clk) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= next_status(status_q, set_vec, clr_vec, MSG_W);
  end

  assign status = status_q;

  // R1: reserved bits never hold a one
  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (status & ~IMPL) == '0);
  // R2 / R4 / R5: every requested set is visible next cycle, even against a clear
  a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_vec & IMPL) != '0) |=> ((status & $past(set_vec & IMPL)) == $past(set_vec & IMPL)));
  // R3: a clear without a competing set leaves the bit at zero
  a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_vec & ~set_vec) != '0) |=> ((status & $past(clr_vec & ~set_vec)) == '0));
  // R5: bits touched by neither path keep their value
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((status ^ $past(status)) & ~$past(set_vec | clr_vec)) == '0));
endmodule

// File: rtl/irq_cpu_port.sv
module irq_cpu_port
  import irq_status_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cpu_valid,
  input  logic       cpu_write,
  input  logic [1:0] cpu_addr,
  input  word_t      cpu_wdata,
  input  word_t      status,
  output word_t      enable,
  output word_t      clr_vec,
  output word_t      cpu_rdata
);
  cpu_reg_e sel;
  logic     wr_en, rd_en, ack_wr, en_wr;
  word_t    enable_q;

  assign sel    = cpu_reg_e'(cpu_addr);
  assign wr_en  = cpu_valid && cpu_write;
  assign rd_en  = cpu_valid && !cpu_write;
  assign ack_wr = wr_en && (sel == CPU_REG_ACK);
  assign en_wr  = wr_en && (sel == CPU_REG_ENABLE);

  always_ff @(posedge clk) begin
    if (!rst_n)     enable_q <= '0;
    else if (en_wr) enable_q <= cpu_wdata;
  end

  assign enable  = enable_q;
  assign clr_vec = ack_wr ? cpu_wdata : '0;

  always_comb begin
    cpu_rdata = '0;
    if (rd_en) begin
      unique case (sel)
        CPU_REG_STATUS: cpu_rdata = status;
        CPU_REG_ENABLE: cpu_rdata = enable_q;
        default:        cpu_rdata = '0;
      endcase
    end
  end

  // R9: enable write is captured exactly
  a_r9_enable_wr: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr |=> (enable == $past(cpu_wdata)));
  // R9: enable holds without a write
  a_r9_enable_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en_wr |=> $stable(enable));
  // R3: acknowledge vector only when an acknowledge write is presented
  a_r3_ack_only: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_valid && cpu_write && cpu_addr == 2'd1) |-> (clr_vec == '0));
endmodule

// File: rtl/irq_line.sv
module irq_line
  import irq_status_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  word_t status,
  input  word_t enable,
  output logic  irq
);
  word_t live;
  logic  irq_q;

  assign live = status & enable;

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |live;
  end

  assign irq = irq_q;

  // R10: nothing pending and enabled means the line drops next cycle
  a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (live == '0) |=> !irq);
  // R10: a rising line traces back to an enabled pending bit
  a_r10_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(status) & $past(enable)) != '0);
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_status_pkg::*;
#(
  parameter int unsigned MSG_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_valid,
  input  logic        host_write,
  input  logic        host_irq_sel,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_status,
  input  logic        cpu_valid,
  input  logic        cpu_write,
  input  logic [1:0]  cpu_addr,
  input  logic [31:0] cpu_wdata,
  output logic [31:0] cpu_rdata,
  input  logic        sleep_mode,
  input  logic        dma_wr_done,
  input  logic        dma_rd_done,
  input  logic        dma_rd_ready,
  output logic        cpu_irq
);
  localparam word_t MSG = msg_mask(MSG_W);

  logic  sleep_hit;
  logic  host_set_wr;
  word_t host_set_vec, set_vec, clr_vec, status, enable;

  irq_sleep_guard u_guard (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_valid   (host_valid),
    .host_irq_sel (host_irq_sel),
    .sleep_mode   (sleep_mode),
    .sleep_hit    (sleep_hit)
  );

  assign host_set_wr  = host_valid && host_write && host_irq_sel;
  assign host_set_vec = host_set_wr ? (host_wdata & MSG) : '0;
  assign set_vec      = host_set_vec |
                        event_vec(sleep_hit, dma_wr_done, dma_rd_done, dma_rd_ready);

  irq_cpu_port u_cpu (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_valid (cpu_valid),
    .cpu_write (cpu_write),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .status    (status),
    .enable    (enable),
    .clr_vec   (clr_vec),
    .cpu_rdata (cpu_rdata)
  );

  irq_status_reg #(.MSG_W(MSG_W)) u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .status  (status)
  );

  irq_line u_line (
    .clk    (clk),
    .rst_n  (rst_n),
    .status (status),
    .enable (enable),
    .irq    (cpu_irq)
  );

  assign host_status = status;

  // R2: host writes never reach the upper half through the message path
  a_r2_host_msg_only: assert property (@(posedge clk) disable iff (!rst_n)
    (host_set_vec & ~MSG) == '0);
  // R6: foreign access during sleep raises bit 31 next cycle
  a_r6_sleep_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && !host_irq_sel && sleep_mode) |=> host_status[BIT_SLEEP]);
  // R8: CPU status read matches the host mirror
  a_r8_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && !cpu_write && cpu_addr == 2'd0) |-> (cpu_rdata == host_status));
endmodule

// File: tb/irq_status_ctrl_bench.sv
module irq_status_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_valid = 0, host_write = 0, host_irq_sel = 0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_status;
  logic        cpu_valid = 0, cpu_write = 0;
  logic [1:0]  cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        sleep_mode = 0, dma_wr_done = 0, dma_rd_done = 0, dma_rd_ready = 0;
  logic        cpu_irq;

  always #4 clk = ~clk;

  irq_status_ctrl u_irq_status_ctrl (
    .clk(clk), .rst_n(rst_n),
    .host_valid(host_valid), .host_write(host_write), .host_irq_sel(host_irq_sel),
    .host_wdata(host_wdata), .host_status(host_status),
    .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .sleep_mode(sleep_mode), .dma_wr_done(dma_wr_done), .dma_rd_done(dma_rd_done),
    .dma_rd_ready(dma_rd_ready), .cpu_irq(cpu_irq)
  );

  typedef struct {
    logic [31:0] st;
    logic        irq;
    logic        chk_rd;
    logic [31:0] rd;
    string       tag;
  } item_t;

  item_t       sb[$];
  int          checks = 0, failures = 0;
  bit          done = 0;
  logic [31:0] m_st = '0, m_en = '0;

  task automatic check32(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Driver: one cycle of stimulus plus the expected post-edge view.
  task automatic step(string tag,
                      logic hv, logic hw, logic hsel, logic [31:0] hd,
                      logic cv, logic cw, logic [1:0] ca, logic [31:0] cd,
                      logic slp, logic dwr, logic drd, logic drdy);
    item_t it;
    logic [31:0] setv, clrv, st_n, en_n;
    @(negedge clk);
    host_valid = hv; host_write = hw; host_irq_sel = hsel; host_wdata = hd;
    cpu_valid = cv; cpu_write = cw; cpu_addr = ca; cpu_wdata = cd;
    sleep_mode = slp; dma_wr_done = dwr; dma_rd_done = drd; dma_rd_ready = drdy;
    setv = '0;
    if (hv && hw && hsel) setv[15:0] = hd[15:0];
    setv[31] = hv && !hsel && slp;
    setv[30] = dwr; setv[29] = drd; setv[28] = drdy;
    clrv = (cv && cw && ca == 2'd1) ? cd : '0;
    st_n = ((m_st & ~clrv) | setv) & 32'hF000_FFFF;
    en_n = (cv && cw && ca == 2'd2) ? cd : m_en;
    it.irq = |(m_st & m_en);
    it.st = st_n;
    it.chk_rd = cv && !cw;
    it.rd = (ca == 2'd0) ? st_n : (ca == 2'd2) ? en_n : 32'h0;
    it.tag = tag;
    sb.push_back(it);
    m_st = st_n; m_en = en_n;
  endtask

  task automatic idle(string tag);
    step(tag, 0,0,0,'0, 0,0,2'd0,'0, 0,0,0,0);
  endtask
  task automatic hwrite(string tag, logic sel, logic [31:0] d, logic slp);
    step(tag, 1,1,sel,d, 0,0,2'd0,'0, slp,0,0,0);
  endtask
  task automatic hread(string tag, logic sel, logic slp);
    step(tag, 1,0,sel,'0, 0,0,2'd0,'0, slp,0,0,0);
  endtask
  task automatic cwrite(string tag, logic [1:0] a, logic [31:0] d);
    step(tag, 0,0,0,'0, 1,1,a,d, 0,0,0,0);
  endtask
  task automatic cread(string tag, logic [1:0] a);
    step(tag, 0,0,0,'0, 1,0,a,'0, 0,0,0,0);
  endtask

  // Monitor: compares outputs just after each edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        check32(it.tag, "status", host_status, it.st);
        check32(it.tag, "irq", {31'b0, cpu_irq}, {31'b0, it.irq});
        if (it.chk_rd) check32(it.tag, "rdata", cpu_rdata, it.rd);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R11: reset state seen at the ports
    check32("R11", "status in reset", host_status, 32'h0);
    check32("R11", "irq in reset", {31'b0, cpu_irq}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    idle("R11");
    cread("R11", 2'd2);
    // R9: spare and acknowledge registers read zero
    cread("R9", 2'd1);
    cread("R9", 2'd3);
    // R2: message bits set and accumulate
    hwrite("R2", 1, 32'h0000_00A5, 0);
    hwrite("R2", 1, 32'h0000_0100, 0);
    // R1: upper data bits of a host write are ignored
    hwrite("R1", 1, 32'hFFFF_0000, 0);
    // R8: CPU view matches mirror
    cread("R8", 2'd0);
    // R3: acknowledge clears selected bits only
    cwrite("R3", 2'd1, 32'h0000_0005);
    // R1: acknowledge of reserved bits has no visible effect
    cwrite("R1", 2'd1, 32'h0FFF_0000);
    cread("R1", 2'd0);
    // R10: enable bit 7 then the line rises one cycle later
    cwrite("R10", 2'd2, 32'h0000_0080);
    idle("R10");
    cread("R9", 2'd2);
    cwrite("R10", 2'd1, 32'h0000_0080);
    idle("R10");
    idle("R10");
    // R5: DMA pulses latch until acknowledged
    step("R5", 0,0,0,'0, 0,0,2'd0,'0, 0,1,0,0);
    step("R5", 0,0,0,'0, 0,0,2'd0,'0, 0,0,1,0);
    step("R5", 0,0,0,'0, 0,0,2'd0,'0, 0,0,0,1);
    idle("R5");
    cwrite("R5", 2'd1, 32'h2000_0000);
    // R4: set and clear of the same bit together
    step("R4", 1,1,1,32'h0000_0001, 1,1,2'd1,32'h0000_0001, 0,0,0,0);
    step("R4", 0,0,0,'0, 1,1,2'd1,32'h4000_0000, 0,1,0,0);
    cwrite("R4", 2'd1, 32'hFFFF_FFFF);
    // R7: exempt accesses during sleep and foreign access while awake
    hread("R7", 1, 1);
    hwrite("R7", 1, 32'h0000_0002, 1);
    hread("R7", 0, 0);
    hwrite("R7", 0, 32'h0000_0004, 0);
    // R6: foreign read and write during sleep raise bit 31
    hread("R6", 0, 1);
    cread("R8", 2'd0);
    cwrite("R6", 2'd1, 32'h8000_0000);
    hwrite("R6", 0, 32'h0000_0008, 1);
    // R10: violation reaches the line when enabled
    cwrite("R10", 2'd2, 32'h8000_0000);
    idle("R10");
    idle("R10");
    // R9: write to status register ignored, full enable readback
    cwrite("R9", 2'd0, 32'hFFFF_FFFF);
    cwrite("R9", 2'd2, 32'hFFFF_FFFF);
    cread("R9", 2'd2);
    cwrite("R3", 2'd1, 32'hFFFF_FFFF);
    idle("R10");
    idle("R10");
    idle("R10");
    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule